// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames, delivered as a byte stream with first-byte and last-byte markers, and stores each one in a buffer owned by a ring of descriptors kept in a word-addressed synchronous memory. Each descriptor takes two consecutive memory words. The first word holds the buffer address and two flags: one says who owns the buffer, and one closes the ring. The second word is a status word that the block fills in with the frame length and the address-match classification.

While the receiver is enabled, the walker reads the descriptor at its current position. If software owns it, the walker keeps the buffer address and waits for a frame. The frame bytes are packed little-endian into buffer words. At the end of the frame the block writes the status word. It then writes the first word back with the ownership bit set, which hands the buffer to software. After that it moves to the next descriptor. Software returns a buffer by clearing the ownership bit and zeroing the status word.

Three sticky flags report what has happened: a frame was stored, a frame was dropped, or a descriptor was found still owned by software. Each flag is cleared by pulsing its bit on the clear input. Turning the receiver off and on again restarts the walk at the ring base.

Top module: `rxq_ring_writer`

## Requirements
- R1: After reset, and whenever `rx_en` is low, the block makes no memory access, accepts no frame and raises no status flag; `sts` reads 0 after reset.
- R2: Byte k of a frame is written to buffer word k/4, in bit lane 8*(k%4). The buffer word address is bits AW+1:2 of descriptor word 0. Unused byte lanes of the final partial word are written as zero.
- R3: The status word (descriptor word 1, at descriptor address + 1) holds the stored byte count in bits 10:0 and zeros in bits 22:11. Bits 31:23 hold `in_match[8:0]`, sampled with the last byte. In that field, bit 8 is broadcast, 7 multicast hash, 6 unicast hash, 5 external match, 4 unknown address, and 3..0 specific-address matches 4..1.
- R4: After the status word is written, descriptor word 0 is written back in the next cycle with bit 0 (ownership) set and all other bits unchanged.
- R5: Descriptors are used in order at ring_base + 2*i. After a descriptor whose word 0 bit 1 (wrap) is set, the next descriptor used is the one at `ring_base`.
- R6: After MAX_DESC descriptors with no wrap bit, the walk returns to `ring_base` anyway.
- R7: Bytes beyond BUF_BYTES are not written, and the length field then reports BUF_BYTES.
- R8: A descriptor read with bit 0 set raises the buffer-unavailable flag (`sts[2]`), and nothing is written to it. The walker re-reads the same descriptor until software frees it, then uses it.
- R9: A first byte that arrives while the block holds no free descriptor drops the whole frame, with no memory write, and sets the overrun flag (`sts[1]`).
- R10: `sts[0]` is set when a frame is handed over. Every `sts` bit stays set until its `sts_clr` bit is pulsed; a set event in the same cycle wins over the clear.
- R11: Dropping `rx_en` and raising it again makes the next frame go to the descriptor at `ring_base`, wherever the walk had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| ring_base | input | AW | Word address of the first descriptor |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Frame byte |
| in_match | input | 9 | Address-match class, valid with the last byte |
| sts_clr | input | 3 | Write-one-to-clear for the status flags |
| sts | output | 3 | Flags: bit 0 frame stored, bit 1 overrun, bit 2 buffer unavailable |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |

## Verification
The hardest cases to reach from the ports are the ones where the ring has caught up with software. The walker then sits on a descriptor it cannot use, and a forced wrap then lands on a descriptor that is still owned. The stimulus reaches both by filling every descriptor without returning any. A frame is sent while the walker is stalled, to show that it is dropped. The owned descriptor is then freed in the bench memory, and the next frame is shown to land there. A disable in the middle of the ring, followed by a ring with no wrap bits, drives both the restart at the base and the count-based wrap.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int LEN_W = 11;
   localparam int CLS_W = 9;
   localparam int STS_N = 3;
   localparam int STS_RCV = 0;
   localparam int STS_OVR = 1;
   localparam int STS_BNA = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_FWAIT,
      ST_READY,
      ST_RECV,
      ST_FLUSH,
      ST_STAT,
      ST_OWN
   } wr_state_e;
endpackage

// File: rtl/rxq_packer.sv
module rxq_packer #(
   parameter int BUF_BYTES = 1536,
   localparam int CW = $clog2(BUF_BYTES + 1),
   localparam int WIW = CW - 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           byte_vld,
   input  logic [7:0]     byte_in,
   output logic           word_vld,
   output logic [31:0]    word_out,
   output logic [WIW-1:0] word_idx,
   output logic           part_vld,
   output logic [31:0]    part_word,
   output logic [WIW-1:0] part_idx,
   output logic [CW-1:0]  len
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] pos;
   logic [31:0]   sh;
   logic [31:0]   sh_nxt;
   logic [1:0]    lane;
   logic          take;

   always_comb begin
      pos    = start ? '0 : cnt;
      lane   = pos[1:0];
      take   = byte_vld && (start || (cnt < CW'(BUF_BYTES)));
      sh_nxt = start ? '0 : sh;
      sh_nxt[8*lane +: 8] = byte_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         sh       <= '0;
         word_vld <= 1'b0;
         word_out <= '0;
         word_idx <= '0;
      end else begin
         word_vld <= 1'b0;
         if (take) begin
            cnt <= pos + CW'(1);
            sh  <= sh_nxt;
            if (lane == 2'd3) begin
               word_vld <= 1'b1;
               word_out <= sh_nxt;
               word_idx <= pos[CW-1:2];
            end
         end
      end
   end

   for (genvar l = 0; l < 4; l++) begin : g_lane
      assign part_word[8*l +: 8] = (cnt[1:0] > 2'(l)) ? sh[8*l +: 8] : 8'h00;
   end

   assign part_vld = (cnt[1:0] != 2'd0);
   assign part_idx = cnt[CW-1:2];
   assign len      = cnt;
endmodule

// File: rtl/rxq_sticky.sv
module rxq_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/rxq_ring_writer.sv
module rxq_ring_writer
   import rxq_pkg::*;
#(
   parameter int AW        = 12,
   parameter int BUF_BYTES = 1536,
   parameter int MAX_DESC  = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [AW-1:0]    ring_base,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [7:0]       in_data,
   input  logic [CLS_W-1:0] in_match,
   input  logic [STS_N-1:0] sts_clr,
   output logic [STS_N-1:0] sts,
   output logic             mem_en,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata
);
   localparam int CW  = $clog2(BUF_BYTES + 1);
   localparam int WIW = CW - 2;
   localparam int IW  = $clog2(MAX_DESC);

   if (BUF_BYTES < 4 || BUF_BYTES % 4 != 0 || BUF_BYTES > 2047) begin : g_bad_buf
      $error("BUF_BYTES must be a multiple of 4 between 4 and 2044");
   end
   if (MAX_DESC < 2 || MAX_DESC > 1024) begin : g_bad_desc
      $error("MAX_DESC must lie between 2 and 1024");
   end
   if (AW < 4 || AW > 30) begin : g_bad_aw
      $error("AW must lie between 4 and 30");
   end

   wr_state_e        st, st_n;
   logic [AW-1:0]    ptr;
   logic [IW-1:0]    idx;
   logic [31:0]      w0;
   logic [CLS_W-1:0] match_q;
   logic [AW-1:0]    buf_w;
   logic             wrap_now;
   logic [STS_N-1:0] sts_set;

   logic             pk_start, pk_vld, pk_wv, pk_pv;
   logic [31:0]      pk_word, pk_part;
   logic [WIW-1:0]   pk_wi, pk_pi;
   logic [CW-1:0]    pk_len;

   rxq_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
      .clk(clk), .rst_n(rst_n), .start(pk_start), .byte_vld(pk_vld),
      .byte_in(in_data), .word_vld(pk_wv), .word_out(pk_word),
      .word_idx(pk_wi), .part_vld(pk_pv), .part_word(pk_part),
      .part_idx(pk_pi), .len(pk_len)
   );

   rxq_sticky #(.N(STS_N)) u_sts (
      .clk(clk), .rst_n(rst_n), .set(sts_set), .clr(sts_clr), .q(sts)
   );

   assign buf_w    = w0[AW+1:2];
   assign wrap_now = w0[1] || (idx == IW'(MAX_DESC - 1));

   always_comb begin
      st_n      = st;
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = ptr;
      mem_wdata = '0;
      pk_start  = 1'b0;
      pk_vld    = 1'b0;
      sts_set   = '0;
      sts_set[STS_OVR] = rx_en && in_valid && in_sof && (st != ST_READY);
      unique case (st)
         ST_IDLE:  if (rx_en) st_n = ST_FETCH;
         ST_FETCH: begin
            mem_en = 1'b1;
            st_n   = ST_FWAIT;
         end
         ST_FWAIT: begin
            if (mem_rdata[0]) begin
               sts_set[STS_BNA] = 1'b1;
               st_n = ST_FETCH;
            end else begin
               st_n = ST_READY;
            end
         end
         ST_READY: begin
            if (in_valid && in_sof) begin
               pk_start = 1'b1;
               pk_vld   = 1'b1;
               st_n     = in_eof ? ST_FLUSH : ST_RECV;
            end
         end
         ST_RECV: begin
            pk_vld = in_valid;
            if (in_valid && in_eof) st_n = ST_FLUSH;
            if (pk_wv) begin
               mem_en    = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = buf_w + AW'(pk_wi);
               mem_wdata = pk_word;
            end
         end
         ST_FLUSH: begin
            if (pk_wv) begin
               mem_en    = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = buf_w + AW'(pk_wi);
               mem_wdata = pk_word;
            end else if (pk_pv) begin
               mem_en    = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = buf_w + AW'(pk_pi);
               mem_wdata = pk_part;
            end
            st_n = ST_STAT;
         end
         ST_STAT: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ptr + AW'(1);
            mem_wdata = {match_q, 12'h000, LEN_W'(pk_len)};
            st_n      = ST_OWN;
         end
         ST_OWN: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = w0 | 32'h1;
            sts_set[STS_RCV] = 1'b1;
            st_n      = ST_FETCH;
         end
         default: st_n = ST_IDLE;
      endcase
      if (!rx_en) st_n = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ptr     <= '0;
         idx     <= '0;
         w0      <= '0;
         match_q <= '0;
      end else begin
         st <= st_n;
         if (!rx_en || st == ST_IDLE) begin
            ptr <= ring_base;
            idx <= '0;
         end else if (st == ST_OWN) begin
            if (wrap_now) begin
               ptr <= ring_base;
               idx <= '0;
            end else begin
               ptr <= ptr + AW'(2);
               idx <= idx + IW'(1);
            end
         end
         if (st == ST_FWAIT && !mem_rdata[0]) w0 <= mem_rdata;
         if (in_valid && in_eof &&
             ((st == ST_READY && in_sof) || st == ST_RECV))
            match_q <= in_match;
      end
   end
endmodule

// File: rtl/rxq_ring_chk.sv
module rxq_ring_chk
   import rxq_pkg::*;
#(
   parameter int AW        = 12,
   parameter int BUF_BYTES = 1536
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_en,
   input logic             in_valid,
   input logic             in_sof,
   input logic [STS_N-1:0] sts_clr,
   input logic [STS_N-1:0] sts,
   input logic             mem_en,
   input logic             mem_we,
   input logic [AW-1:0]    mem_addr,
   input logic [31:0]      mem_wdata,
   input logic [31:0]      mem_rdata,
   input wr_state_e        st
);
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !mem_en); // R1

   AST_OWN_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STAT && mem_we && rx_en) |=>
      (mem_we && mem_wdata[0] && mem_addr == ($past(mem_addr) - AW'(1)))); // R4

   AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STAT && mem_we) |-> (int'(mem_wdata[10:0]) <= BUF_BYTES)); // R7

   AST_BNA_ON_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FWAIT && mem_rdata[0]) |=> sts[STS_BNA]); // R8

   AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && in_valid && in_sof && st != ST_READY) |=> sts[STS_OVR]); // R9

   AST_RCV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[STS_RCV] && !sts_clr[STS_RCV]) |=> sts[STS_RCV]); // R10

   AST_BNA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr[STS_BNA] && !(st == ST_FWAIT && mem_rdata[0])) |=> !sts[STS_BNA]); // R10
endmodule

bind rxq_ring_writer rxq_ring_chk #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
   .in_sof(in_sof), .sts_clr(sts_clr), .sts(sts), .mem_en(mem_en),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_rdata(mem_rdata), .st(st)
);

// File: tb/tb_rxq_ring_writer.sv
`timescale 1ns/1ps
module tb_rxq_ring_writer;
   localparam int AW = 10;
   localparam int BB = 16;
   localparam int MD = 4;
   localparam int RB = 'h100;
   localparam logic [31:0] SENT = 32'hA5A5_5A5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic [AW-1:0] ring_base = AW'(RB);
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]  in_data = '0;
   logic [8:0]  in_match = '0;
   logic [2:0]  sts_clr = '0;
   logic [2:0]  sts;
   logic        mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [0:(1<<AW)-1];
   int wr_cnt = 0;
   int checks = 0;
   int errs = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rxq_ring_writer #(.AW(AW), .BUF_BYTES(BB), .MAX_DESC(MD)) dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_data(in_data), .in_match(in_match), .sts_clr(sts_clr), .sts(sts),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr];
         end
      end
   end

   function automatic int bufw(int i);
      return 'h40 + 8 * i;
   endfunction

   function automatic logic [31:0] w0_of(int i, bit wrap);
      return (32'(bufw(i)) << 2) | {30'b0, wrap, 1'b0};
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic give(int i, bit wrap);
      @(negedge clk);
      mem[RB + 2*i]     <= w0_of(i, wrap);
      mem[RB + 2*i + 1] <= '0;
      for (int w = 0; w < 5; w++) mem[bufw(i) + w] <= SENT;
   endtask

   task automatic send(int n, int seed, logic [8:0] m);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sof   = (k == 0);
         in_eof   = (k == n - 1);
         in_data  = 8'(seed + k);
         in_match = m;
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse_clr(logic [2:0] v);
      @(negedge clk) sts_clr = v;
      @(negedge clk) sts_clr = '0;
      @(negedge clk);
   endtask

   task automatic check_frame(int i, int n, int seed, logic [8:0] m, bit wrap, string req);
      int nw;
      logic [31:0] exp;
      nw = (n > BB) ? BB : n;
      for (int w = 0; w < (nw + 3) / 4; w++) begin
         exp = '0;
         for (int l = 0; l < 4; l++)
            if (4*w + l < nw) exp[8*l +: 8] = 8'(seed + 4*w + l);
         chk(mem[bufw(i) + w] == exp, req, "buffer word", mem[bufw(i) + w], exp);
      end
      if (n > BB)
         chk(mem[bufw(i) + 4] == SENT, "R7", "word past buffer", mem[bufw(i) + 4], SENT);
      exp = {m, 12'h000, 11'(nw)};
      chk(mem[RB + 2*i + 1] == exp, "R3", "status word", mem[RB + 2*i + 1], exp);
      exp = w0_of(i, wrap) | 32'h1;
      chk(mem[RB + 2*i] == exp, "R4", "owned word 0", mem[RB + 2*i], exp);
   endtask

   task automatic t_reset;
      chk(sts == 3'b000, "R1", "status after reset", 32'(sts), 0);
      send(4, 'h01, 9'h000);
      chk(wr_cnt == 0, "R1", "writes while disabled", wr_cnt, 0);
      chk(sts == 3'b000, "R1", "flags while disabled", 32'(sts), 0);
   endtask

   task automatic t_basic;
      give(0, 0); give(1, 0); give(2, 1);
      @(negedge clk) rx_en = 1'b1;
      repeat (6) @(negedge clk);
      send(6, 'h10, 9'h100);
      check_frame(0, 6, 'h10, 9'h100, 0, "R2");
      chk(sts == 3'b001, "R10", "frame flag set", 32'(sts), 1);
      pulse_clr(3'b001);
      chk(sts == 3'b000, "R10", "frame flag cleared", 32'(sts), 0);
   endtask

   task automatic t_order;
      send(8, 'h30, 9'h041);
      check_frame(1, 8, 'h30, 9'h041, 0, "R5");
      send(1, 'h50, 9'h002);
      check_frame(2, 1, 'h50, 9'h002, 1, "R5");
   endtask

   task automatic t_bna;
      int c0;
      repeat (4) @(negedge clk);
      chk(sts[2] == 1'b1, "R8", "unavailable flag", 32'(sts), 32'h4);
      c0 = wr_cnt;
      send(5, 'h60, 9'h000);
      chk(wr_cnt == c0, "R9", "dropped frame writes", wr_cnt, c0);
      chk(sts[1] == 1'b1, "R9", "overrun flag", 32'(sts), 32'h2);
      pulse_clr(3'b010);
      chk(sts[1] == 1'b0, "R10", "overrun cleared", 32'(sts), 0);
      give(0, 0);
      repeat (6) @(negedge clk);
      send(7, 'h70, 9'h010);
      check_frame(0, 7, 'h70, 9'h010, 0, "R8");
   endtask

   task automatic t_trunc;
      give(1, 0);
      repeat (6) @(negedge clk);
      pulse_clr(3'b100);
      chk(sts[2] == 1'b0, "R10", "unavailable cleared", 32'(sts), 0);
      send(20, 'h80, 9'h1FF);
      check_frame(1, 20, 'h80, 9'h1FF, 0, "R7");
   endtask

   task automatic t_restart;
      @(negedge clk) rx_en = 1'b0;
      for (int i = 0; i < 5; i++) give(i, 0);
      @(negedge clk) rx_en = 1'b1;
      repeat (6) @(negedge clk);
      send(5, 'h90, 9'h008);
      check_frame(0, 5, 'h90, 9'h008, 0, "R11");
      for (int i = 1; i < 4; i++) begin
         send(4 + i, 'hA0 + 16*i, 9'h020);
         check_frame(i, 4 + i, 'hA0 + 16*i, 9'h020, 0, "R6");
      end
      give(0, 0);
      repeat (6) @(negedge clk);
      send(3, 'hD0, 9'h080);
      check_frame(0, 3, 'hD0, 9'h080, 0, "R6");
      chk(mem[RB + 8] == w0_of(4, 0), "R6", "fifth descriptor untouched", mem[RB + 8], w0_of(4, 0));
      chk(mem[bufw(4)] == SENT, "R6", "fifth buffer untouched", mem[bufw(4)], SENT);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_order;
      t_bna;
      t_trunc;
      t_restart;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errs++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule